// File: doc/BRIEF.md
# Flash Access Permission Checker

This block sits in front of a flash array and judges each requested read, program or page erase before the request is issued. Software sets up a small set of protection regions for the data partition. Each region is given as a first page, a page count, an enable and one permission bit per operation. The information partition is guarded by one permission entry per page instead.

Regardless of those permissions, the checker refuses any request whose span runs past the end of the selected partition. It never lets the address wrap. It also refuses any program burst whose first and last beats lie in different aligned program windows. While a reset-to-factory (RMA) transition is active, the software-configured permissions are bypassed and every valid operation that passes the geometry checks is allowed.

Each request is presented for one cycle with `req_valid`. The verdict appears one cycle later on `rsp_valid`, `rsp_allow` and `rsp_reason`. The issuing controller forwards the operation only when `rsp_allow` is high. It ends the transaction with an error when `rsp_reason` is non-zero.

Top module: `flash_guard`

## Requirements
- R1: The verdict is registered. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and it is low out of reset. When `rsp_valid` is low, `rsp_allow` is 0 and `rsp_reason` is 0.
- R2: For a data-partition request (`req_part`=0) whose start page lies in an enabled region, the permission bit of that region for the operation decides the verdict. Operation codes are 0 = read, 1 = program and 2 = page erase. A missing permission gives `rsp_reason`=1 (region).
- R3: When several enabled regions contain the start page, the region with the lowest index alone decides the verdict.
- R4: A data-partition request whose start page lies in no enabled region is denied with `rsp_reason`=1.
- R5: For an information-partition request (`req_part`=1), the permission entry of the page holding the start address decides the verdict. A missing permission gives `rsp_reason`=1.
- R6: The last word of a request is the start address plus `req_len` for read and program, and the start address itself for erase. A request whose last word is at or beyond the size of the selected partition is denied with `rsp_reason`=2 (bounds). This applies whatever the permissions are and also during RMA.
- R7: A program request whose first and last words lie in different aligned windows of `WIN_WORDS` words is denied with `rsp_reason`=3 (window). Read and erase requests never give reason 3.
- R8: While `rma_active` is high, a read, program or erase request that has no bounds or window error is allowed in either partition, whatever the region and page permissions are.
- R9: Reasons rank bounds over window over region. Operation code 3 is reserved and is denied with reason 1, even during RMA. `rsp_allow` is 1 exactly when `rsp_reason` is 0 on a valid verdict.
- R10: `win_words` constantly reports the program window size in words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_part | input | 1 | 0 data partition, 1 information partition |
| req_addr | input | ADDR_W (9) | Start word address |
| req_len | input | LEN_W (5) | Number of words minus one |
| rma_active | input | 1 | RMA transition in progress |
| rgn_en | input | NUM_REGIONS (4) | Region enables |
| rgn_base | input | NUM_REGIONS*PG_W (16) | First page of each region, region 0 in the low bits |
| rgn_pages | input | NUM_REGIONS*SZ_W (20) | Page count of each region |
| rgn_rd | input | NUM_REGIONS (4) | Region read permission |
| rgn_prog | input | NUM_REGIONS (4) | Region program permission |
| rgn_erase | input | NUM_REGIONS (4) | Region erase permission |
| info_rd | input | INFO_PAGES (4) | Per-page read permission |
| info_prog | input | INFO_PAGES (4) | Per-page program permission |
| info_erase | input | INFO_PAGES (4) | Per-page erase permission |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Request permitted |
| rsp_reason | output | 2 | 0 none, 1 region, 2 bounds, 3 window |
| win_words | output | 8 | Program window size in words |

## Verification
The bench builds the checker with its defaults: 16 pages of 16 words, 4 information pages, 4 regions and a 4-word program window. It uses a 9-bit address and a 5-bit length. With these values, an address one bit wider than the data partition reaches both sides of each bounds limit. A 31-word burst can cross several windows and pages. Four overlapping regions make priority collisions common under random configuration. Directed cases pin the exact last legal word, window edges, erase with a long length, and RMA with every permission cleared.

// File: rtl/flash_guard_pkg.sv
// Shared encodings for the flash access permission checker.
package flash_guard_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } fg_op_e;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_REGION = 2'd1,
        RSN_BOUNDS = 2'd2,
        RSN_WINDOW = 2'd3
    } fg_reason_e;
endpackage

// File: rtl/fg_region_match.sv
// Priority lookup of the data-partition protection regions.
// Finds the lowest-index enabled region that holds the given page and
// returns its permission bits. Assumes page counts may reach the whole
// partition, so the end page is computed one bit wider.
module fg_region_match #(
    parameter int NUM_REGIONS = 4,
    parameter int PG_W        = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PG_W-1:0]             page,
    input  logic [NUM_REGIONS-1:0]      rgn_en,
    input  logic [NUM_REGIONS*PG_W-1:0] rgn_base,
    input  logic [NUM_REGIONS*(PG_W+1)-1:0] rgn_pages,
    input  logic [NUM_REGIONS-1:0]      rgn_rd,
    input  logic [NUM_REGIONS-1:0]      rgn_prog,
    input  logic [NUM_REGIONS-1:0]      rgn_erase,
    output logic                        found,
    output logic                        perm_rd,
    output logic                        perm_prog,
    output logic                        perm_erase
);
    localparam int SZ_W = PG_W + 1;

    logic [NUM_REGIONS-1:0] hit;
    logic [NUM_REGIONS-1:0] pick;

    // Per-region containment test: base <= page < base + count.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
        logic [PG_W-1:0] base;
        logic [SZ_W:0]   stop;
        assign base   = rgn_base[g*PG_W +: PG_W];
        assign stop   = {2'b00, base} + {1'b0, rgn_pages[g*SZ_W +: SZ_W]};
        assign hit[g] = rgn_en[g] && (page >= base) && ({2'b00, page} < stop);
    end

    // Keep only the lowest-index hit.
    always_comb begin
        pick = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) pick = NUM_REGIONS'(1) << i;
        end
    end

    // Reduce the chosen region to its permission bits.
    assign found      = |pick;
    assign perm_rd    = |(pick & rgn_rd);
    assign perm_prog  = |(pick & rgn_prog);
    assign perm_erase = |(pick & rgn_erase);

    // R3: at most one region decides, and it is an enabled one.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            p_single_winner_r3: assert ($onehot0(pick) && ((pick & ~rgn_en) == '0))
                else $error("region pick not a single enabled region");
        end
    end
endmodule

// File: rtl/fg_geometry.sv
// Bounds and program-window checks for one request.
// Computes the last word touched (start for erase, start+len otherwise)
// one bit wider than the address, so nothing wraps. Assumes the partition
// sizes are given in words.
module fg_geometry
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int LEN_W      = 5,
    parameter int DATA_WORDS = 256,
    parameter int INFO_WORDS = 64,
    parameter int WIN_B      = 2
) (
    input  logic [1:0]        op,
    input  logic              part,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              oob,
    output logic              win_cross
);
    localparam int LAST_W = ADDR_W + 1;

    logic [LAST_W-1:0] last;
    logic [LAST_W-1:0] limit;

    // Last word of the span, never truncated.
    always_comb begin
        last = {1'b0, addr};
        if (op != OP_ERASE) last = last + LAST_W'(len);
    end

    // Selected partition size and the two geometry verdicts.
    assign limit     = part ? LAST_W'(INFO_WORDS) : LAST_W'(DATA_WORDS);
    assign oob       = last >= limit;
    assign win_cross = (op == OP_PROG) && (({1'b0, addr} >> WIN_B) != (last >> WIN_B));
endmodule

// File: rtl/flash_guard.sv
// Flash access permission checker (top).
// Judges each request against bounds, program window, and either the
// data-partition regions or the per-page information permissions, with an
// RMA bypass. The verdict is registered: one cycle of latency.
// Assumes PAGE_WORDS and WIN_WORDS are powers of two.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int PAGE_WORDS  = 16,
    parameter int NUM_PAGES   = 16,
    parameter int INFO_PAGES  = 4,
    parameter int NUM_REGIONS = 4,
    parameter int WIN_WORDS   = 4,
    parameter int LEN_W       = 5,
    localparam int OFF_W      = $clog2(PAGE_WORDS),
    localparam int PG_W       = $clog2(NUM_PAGES),
    localparam int IP_W       = (INFO_PAGES > 1) ? $clog2(INFO_PAGES) : 1,
    localparam int SZ_W       = PG_W + 1,
    localparam int ADDR_W     = OFF_W + PG_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic                        req_part,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [LEN_W-1:0]            req_len,
    input  logic                        rma_active,
    input  logic [NUM_REGIONS-1:0]      rgn_en,
    input  logic [NUM_REGIONS*PG_W-1:0] rgn_base,
    input  logic [NUM_REGIONS*SZ_W-1:0] rgn_pages,
    input  logic [NUM_REGIONS-1:0]      rgn_rd,
    input  logic [NUM_REGIONS-1:0]      rgn_prog,
    input  logic [NUM_REGIONS-1:0]      rgn_erase,
    input  logic [INFO_PAGES-1:0]       info_rd,
    input  logic [INFO_PAGES-1:0]       info_prog,
    input  logic [INFO_PAGES-1:0]       info_erase,
    output logic                        rsp_valid,
    output logic                        rsp_allow,
    output logic [1:0]                  rsp_reason,
    output logic [7:0]                  win_words
);
    localparam int WIN_B = $clog2(WIN_WORDS);

    logic oob, win_cross;
    logic found, d_rd, d_prog, d_erase;
    logic [PG_W-1:0] page;
    logic [IP_W-1:0] ipage;
    logic permitted;
    fg_reason_e reason_d;

    assign page  = req_addr[OFF_W +: PG_W];
    assign ipage = req_addr[OFF_W +: IP_W];

    fg_geometry #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .DATA_WORDS(NUM_PAGES * PAGE_WORDS), .INFO_WORDS(INFO_PAGES * PAGE_WORDS),
        .WIN_B(WIN_B)
    ) u_geo (
        .op(req_op), .part(req_part), .addr(req_addr), .len(req_len),
        .oob(oob), .win_cross(win_cross)
    );

    fg_region_match #(.NUM_REGIONS(NUM_REGIONS), .PG_W(PG_W)) u_rgn (
        .clk(clk), .rst_n(rst_n), .page(page),
        .rgn_en(rgn_en), .rgn_base(rgn_base), .rgn_pages(rgn_pages),
        .rgn_rd(rgn_rd), .rgn_prog(rgn_prog), .rgn_erase(rgn_erase),
        .found(found), .perm_rd(d_rd), .perm_prog(d_prog), .perm_erase(d_erase)
    );

    // Permission for the operation from the partition's own table.
    always_comb begin
        permitted = 1'b0;
        unique case (req_op)
            OP_READ:  permitted = req_part ? info_rd[ipage]    : (found && d_rd);
            OP_PROG:  permitted = req_part ? info_prog[ipage]  : (found && d_prog);
            OP_ERASE: permitted = req_part ? info_erase[ipage] : (found && d_erase);
            default:  permitted = 1'b0;
        endcase
    end

    // Rank the reasons: bounds, window, reserved op, then RMA bypass or table.
    always_comb begin
        if (oob)                      reason_d = RSN_BOUNDS;
        else if (win_cross)           reason_d = RSN_WINDOW;
        else if (req_op == OP_RSVD)   reason_d = RSN_REGION;
        else if (rma_active)          reason_d = RSN_NONE;
        else if (permitted)           reason_d = RSN_NONE;
        else                          reason_d = RSN_REGION;
    end

    // Register the verdict; outputs are quiet without a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_reason <= RSN_NONE;
        end else begin
            rsp_valid  <= req_valid;
            rsp_allow  <= req_valid && (reason_d == RSN_NONE);
            rsp_reason <= req_valid ? reason_d : RSN_NONE;
        end
    end

    assign win_words = 8'(WIN_WORDS);

    // R1: the verdict follows the request by exactly one cycle.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("verdict missing one cycle after request");

    // R9: allow and a non-zero reason never appear together.
    p_allow_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_valid && rsp_reason == RSN_NONE))
        else $error("allow with an error reason");

    // R6: an out-of-range span always ends as a bounds error.
    p_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && oob) |=> (rsp_reason == RSN_BOUNDS && !rsp_allow))
        else $error("out-of-range span not reported");

    // R7: erase and read never report a window error.
    p_window_prog_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != OP_PROG) |=> (rsp_reason != RSN_WINDOW))
        else $error("window error on a non-program request");

    // R8: RMA lets every valid, geometrically sound request through.
    p_rma_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rma_active && req_op != OP_RSVD && !oob && !win_cross) |=> rsp_allow)
        else $error("RMA bypass did not allow");
endmodule

// File: tb/sim_flash_guard.sv
// Bench for flash_guard: directed corners plus seeded random requests,
// each compared with a reference function built from the requirements.
module sim_flash_guard;
    localparam int PW = 16, NP = 16, IPG = 4, NR = 4, WW = 4, LW = 5;
    localparam int PG_W = 4, SZ_W = 5, AW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic req_part = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic rma_active = 1'b0;
    logic [NR-1:0] rgn_en = '0, rgn_rd = '0, rgn_prog = '0, rgn_erase = '0;
    logic [NR*PG_W-1:0] rgn_base = '0;
    logic [NR*SZ_W-1:0] rgn_pages = '0;
    logic [IPG-1:0] info_rd = '0, info_prog = '0, info_erase = '0;
    logic rsp_valid, rsp_allow;
    logic [1:0] rsp_reason;
    logic [7:0] win_words;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_part(req_part), .req_addr(req_addr), .req_len(req_len),
        .rma_active(rma_active), .rgn_en(rgn_en), .rgn_base(rgn_base),
        .rgn_pages(rgn_pages), .rgn_rd(rgn_rd), .rgn_prog(rgn_prog),
        .rgn_erase(rgn_erase), .info_rd(info_rd), .info_prog(info_prog),
        .info_erase(info_erase), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_reason(rsp_reason), .win_words(win_words)
    );

    // Expected reason from the requirements (R2-R9).
    function automatic int exp_reason();
        int last, size, page, w;
        bit perm;
        last = int'(req_addr) + ((req_op == 2'd2) ? 0 : int'(req_len));
        size = req_part ? IPG * PW : NP * PW;
        if (last >= size) return 2;
        if (req_op == 2'd1 && (int'(req_addr) / WW) != (last / WW)) return 3;
        if (req_op == 2'd3) return 1;
        if (rma_active) return 0;
        page = int'(req_addr) / PW;
        perm = 1'b0;
        if (req_part) begin
            perm = (req_op == 0) ? info_rd[page] : (req_op == 1) ? info_prog[page] : info_erase[page];
        end else begin
            for (int r = NR - 1; r >= 0; r--) begin
                int b, n;
                b = int'(rgn_base[r*PG_W +: PG_W]);
                n = int'(rgn_pages[r*SZ_W +: SZ_W]);
                if (rgn_en[r] && page >= b && page < b + n) begin
                    w = r;
                    perm = (req_op == 0) ? rgn_rd[w] : (req_op == 1) ? rgn_prog[w] : rgn_erase[w];
                end
            end
        end
        return perm ? 0 : 1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply one request at a falling edge, check the verdict one cycle later.
    task automatic run(input string tag, input logic [1:0] op, input logic part,
                       input int addr, input int len);
        int er;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_part = part;
        req_addr = AW'(addr); req_len = LW'(len);
        er = exp_reason();
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " reason"}, 32'(rsp_reason), 32'(er));
        check({tag, " allow"}, 32'(rsp_allow), 32'(er == 0));
    endtask

    task automatic set_rgn(input int r, input bit en, input int base, input int n,
                           input bit rd, input bit pg, input bit er);
        rgn_en[r] = en; rgn_rd[r] = rd; rgn_prog[r] = pg; rgn_erase[r] = er;
        rgn_base[r*PG_W +: PG_W] = PG_W'(base);
        rgn_pages[r*SZ_W +: SZ_W] = SZ_W'(n);
    endtask

    initial begin
        int seed;
        seed = 32'h1d5a;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        check("R1 reset allow", 32'(rsp_allow), 32'd0);
        check("R10 window status", 32'(win_words), 32'(WW));

        // R2 / R4: single region, pages 2..4, read only.
        set_rgn(0, 1, 2, 3, 1, 0, 0);
        run("R2 read allowed", 2'd0, 1'b0, 2*PW, 0);
        run("R2 program denied", 2'd1, 1'b0, 3*PW, 0);
        run("R4 page after region", 2'd0, 1'b0, 5*PW, 0);
        run("R4 page before region", 2'd0, 1'b0, 1*PW + 15, 0);
        // R1: idle cycle after a response is quiet.
        @(negedge clk);
        check("R1 idle valid", 32'(rsp_valid), 32'd0);
        check("R1 idle reason", 32'(rsp_reason), 32'd0);

        // R3: region 1 overlaps with full rights; region 0 (read only) wins.
        set_rgn(1, 1, 0, 16, 1, 1, 1);
        run("R3 lower index wins", 2'd2, 1'b0, 3*PW, 0);
        run("R3 outside region0", 2'd2, 1'b0, 7*PW, 0);
        set_rgn(0, 0, 2, 3, 1, 0, 0);
        run("R3 disabled region skipped", 2'd2, 1'b0, 3*PW, 0);

        // R6: exact edge of the data partition and information partition.
        run("R6 last legal word", 2'd0, 1'b0, 255 - 3, 3);
        run("R6 one past end", 2'd0, 1'b0, 255 - 3, 4);
        run("R6 address beyond", 2'd2, 1'b0, 300, 0);
        run("R6 info past end", 2'd0, 1'b1, 60, 4);

        // R7: window edges; erase ignores length.
        run("R7 within window", 2'd1, 1'b0, 8, 3);
        run("R7 crosses window", 2'd1, 1'b0, 9, 3);
        run("R7 read crossing ok", 2'd0, 1'b0, 9, 3);
        run("R7 erase long len", 2'd2, 1'b0, 9, 31);

        // R9: reserved op and ranking.
        run("R9 reserved op", 2'd3, 1'b0, 16, 0);
        run("R9 bounds over window", 2'd1, 1'b0, 254, 5);

        // R5: per-page information permissions.
        info_rd = 4'b0101; info_prog = 4'b0010; info_erase = 4'b1000;
        run("R5 info page0 read", 2'd0, 1'b1, 5, 0);
        run("R5 info page1 read", 2'd0, 1'b1, 20, 0);
        run("R5 info page1 prog", 2'd1, 1'b1, 20, 0);
        run("R5 info page3 erase", 2'd2, 1'b1, 50, 0);

        // R8: RMA with all permissions cleared.
        rgn_en = '0; info_rd = '0; info_prog = '0; info_erase = '0;
        rma_active = 1'b1;
        run("R8 rma data erase", 2'd2, 1'b0, 100, 0);
        run("R8 rma info prog", 2'd1, 1'b1, 33, 2);
        run("R8 rma still bounds", 2'd0, 1'b1, 64, 0);
        run("R8 rma still window", 2'd1, 1'b0, 3, 1);
        rma_active = 1'b0;

        // Random mix covering R2-R9.
        for (int i = 0; i < 1500; i++) begin
            if (i % 20 == 0) begin
                for (int r = 0; r < NR; r++)
                    set_rgn(r, $urandom_range(0, 3) != 0, $urandom_range(0, 15),
                            $urandom_range(0, 8), $urandom_range(0, 1),
                            $urandom_range(0, 1), $urandom_range(0, 1));
                info_rd = IPG'($urandom); info_prog = IPG'($urandom);
                info_erase = IPG'($urandom);
                rma_active = ($urandom_range(0, 5) == 0);
            end
            run("R2 random", 2'($urandom), 1'($urandom),
                ($urandom_range(0, 3) == 0) ? $urandom_range(0, 511) : $urandom_range(0, 255),
                $urandom_range(0, 31));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule